// File: doc/BRIEF.md
# Packet-to-Cell Segmenter with Trailer

This block takes one variable-length packet at a time as a byte stream, marked with start and end strobes, and turns it into a run of fixed 48-byte cell payloads. After the last data byte it inserts zero bytes. The count of zero bytes is chosen so that an 8-byte trailer fills the final eight byte slots of a cell. The trailer holds a user byte, an indicator byte fixed at zero, the 16-bit data length and a CRC-32. The CRC covers the data, the padding and the first four trailer bytes.

The output is a byte stream with a valid/ready handshake. A strobe marks the first byte of every cell. A flag marks the final byte of the packet's final cell, so that a downstream header builder can set the end-of-packet bit in that cell's header type field. Data bytes pass straight through, with no storage. Back-pressure on the output therefore stalls the input, the position counters and the CRC together.

Top module: `cellSegmenter`

## Requirements
- R1: Every cell is exactly 48 output bytes. `cellStart` is high on the first output byte after reset, and on every 48th byte after it, and on no other byte.
- R2: The data bytes leave in arrival order and unchanged, with no byte lost or repeated.
- R3: Let L be the number of data bytes. Exactly P zero bytes follow the data, where P = (48 − (L + 8) mod 48) mod 48, so that L + P + 8 is a multiple of 48. When the last data byte leaves fewer than 8 free slots in its cell, a whole extra cell of padding and trailer follows.
- R4: The trailer is sent in a fixed order. Byte 0 is the `pktUser` value present on the beat that carries `inEop`. Byte 1 is 0x00. Bytes 2–3 are the length, most significant byte first.
- R5: The length field equals L, the data bytes only. It counts neither padding nor trailer.
- R6: Trailer bytes 4–7 carry the complement of a CRC-32, most significant byte first. The CRC uses polynomial 0x04C11DB7 and an all-ones preset, and shifts each byte in MSB first. It runs over the data, the padding and trailer bytes 0–3.
- R7: `lastCell` is high on the 48th byte of the packet's final cell (trailer byte 7) and on no other byte.
- R8: While `outReady` is low, no byte is consumed and the offered output byte holds. `inReady` is high only during the data phase, and only while `outReady` is high.
- R9: After reset `outValid` is low while no input is offered. Each new packet starts at a fresh cell, with a fresh CRC and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Input byte accepted when high with inValid |
| inData | input | 8 | Packet data byte |
| inSop | input | 1 | First byte of packet |
| inEop | input | 1 | Last byte of packet |
| pktUser | input | 8 | User byte for the trailer, sampled with inEop |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Downstream accepts output byte |
| outData | output | 8 | Cell payload byte |
| cellStart | output | 1 | First byte of a cell |
| lastCell | output | 1 | Final byte of the packet's final cell |

## Verification
The stall assertion takes for granted that the source follows the valid/ready rule. Once it offers a byte, it keeps `inValid`, `inData` and the markers unchanged until `inReady` accepts it, because data bytes go through to the output without a register. The stimulus drops `inValid` at random only when no byte is pending. It also toggles `outReady` at random. It offers exactly one packet at a time, with `inSop` on the first byte and `inEop` on the last, and lengths stay below 65536. Directed lengths place the end of the data exactly at slot 40, at slot 41 and on a cell boundary.

// File: rtl/segPkg.sv
package segPkg;
  localparam int TRL_BYTES = 8;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  typedef enum logic [1:0] {SRC_IN, SRC_PAD, SRC_TRL} srcSel_e;

  typedef struct packed {
    logic    take;     // output handshake this cycle
    logic    crcEn;    // fold outData into CRC
    logic    restart;  // byte is first of packet
    logic    endBeat;  // byte is last data byte
    logic    clear;    // last trailer byte leaves
    srcSel_e src;
    logic [2:0] trlIdx;
  } segCtl_t;

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import segPkg::*;
#(
  parameter int CELL_BYTES = 48
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inSop,
  input  logic    inEop,
  input  logic    outReady,
  output logic    inReady,
  output logic    outValid,
  output logic    cellStart,
  output logic    lastCell,
  output segCtl_t ctl
);
  localparam int POS_W = $clog2(CELL_BYTES);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CELL_BYTES - 1);
  localparam logic [POS_W-1:0] TRL_POS  = POS_W'(CELL_BYTES - TRL_BYTES);

  typedef enum logic [1:0] {ST_DATA, ST_PAD, ST_TRL} st_e;

  st_e st;
  logic [POS_W-1:0] pos, posNext;
  logic [2:0] tIdx;
  logic take;

  assign posNext = (pos == LAST_POS) ? '0 : pos + 1'b1;

  always_comb begin
    outValid  = (st == ST_DATA) ? inValid : 1'b1;
    inReady   = (st == ST_DATA) && outReady;
    take      = outValid && outReady;
    cellStart = outValid && (pos == '0);
    lastCell  = outValid && (st == ST_TRL) && (tIdx == 3'd7);
    ctl.take    = take;
    ctl.src     = (st == ST_DATA) ? SRC_IN : ((st == ST_PAD) ? SRC_PAD : SRC_TRL);
    ctl.crcEn   = take && ((st != ST_TRL) || !tIdx[2]);
    ctl.restart = take && (st == ST_DATA) && inSop;
    ctl.endBeat = take && (st == ST_DATA) && inEop;
    ctl.clear   = take && (st == ST_TRL) && (tIdx == 3'd7);
    ctl.trlIdx  = tIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st   <= ST_DATA;
      pos  <= '0;
      tIdx <= '0;
    end else if (take) begin
      pos <= posNext;
      unique case (st)
        ST_DATA: if (inEop) st <= (posNext == TRL_POS) ? ST_TRL : ST_PAD;
        ST_PAD:  if (posNext == TRL_POS) st <= ST_TRL;
        default: begin
          tIdx <= tIdx + 3'd1;
          if (tIdx == 3'd7) st <= ST_DATA;
        end
      endcase
    end
  end

  // R1
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rstN) pos <= LAST_POS);
  // R3
  trailer_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.src == SRC_TRL && tIdx == 3'd0) |-> pos == TRL_POS);
  // R7
  last_at_end_chk: assert property (@(posedge clk) disable iff (!rstN) lastCell |-> pos == LAST_POS);
  // R8
  ready_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (ctl.src == SRC_IN && outReady));
endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  segCtl_t    ctl,
  input  logic [7:0] inData,
  input  logic [7:0] pktUser,
  output logic [7:0] outData
);
  logic [31:0] crc, crcBase;
  logic [15:0] lenCnt;
  logic [7:0]  userReg;

  always_comb begin
    unique case (ctl.src)
      SRC_IN:  outData = inData;
      SRC_PAD: outData = 8'h00;
      default: begin
        unique case (ctl.trlIdx)
          3'd0: outData = userReg;
          3'd1: outData = 8'h00;
          3'd2: outData = lenCnt[15:8];
          3'd3: outData = lenCnt[7:0];
          3'd4: outData = ~crc[31:24];
          3'd5: outData = ~crc[23:16];
          3'd6: outData = ~crc[15:8];
          default: outData = ~crc[7:0];
        endcase
      end
    endcase
    crcBase = ctl.restart ? 32'hFFFF_FFFF : crc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crc     <= 32'hFFFF_FFFF;
      lenCnt  <= '0;
      userReg <= '0;
    end else if (ctl.clear) begin
      crc    <= 32'hFFFF_FFFF;
      lenCnt <= '0;
    end else begin
      if (ctl.crcEn) crc <= crcByte(crcBase, outData);
      if (ctl.take && ctl.src == SRC_IN) lenCnt <= ctl.restart ? 16'd1 : lenCnt + 16'd1;
      if (ctl.endBeat) userReg <= pktUser;
    end
  end

  // R5
  pad_len_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.take && ctl.src == SRC_PAD) |=> $stable(lenCnt));
  // R6
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.take) |=> $stable(crc));
endmodule

// File: rtl/cellSegmenter.sv
module cellSegmenter
  import segPkg::*;
#(
  parameter int CELL_BYTES = 48
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  input  logic [7:0] inData,
  input  logic       inSop,
  input  logic       inEop,
  input  logic [7:0] pktUser,
  output logic       outValid,
  input  logic       outReady,
  output logic [7:0] outData,
  output logic       cellStart,
  output logic       lastCell
);
  segCtl_t ctl;

  segCtrl #(.CELL_BYTES(CELL_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .outReady(outReady), .inReady(inReady), .outValid(outValid),
    .cellStart(cellStart), .lastCell(lastCell), .ctl(ctl)
  );

  segDatapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .pktUser(pktUser),
    .outData(outData)
  );

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
  // R1
  start_not_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    cellStart |-> !lastCell);
endmodule

// File: tb/cellSegmenter_tb.sv
module cellSegmenter_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 0, inSop = 0, inEop = 0, outReady = 0;
  logic [7:0] inData = 0, pktUser = 0;
  logic inReady, outValid, cellStart, lastCell;
  logic [7:0] outData;
  int nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  cellSegmenter u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inSop(inSop), .inEop(inEop), .pktUser(pktUser), .outValid(outValid),
    .outReady(outReady), .outData(outData), .cellStart(cellStart), .lastCell(lastCell)
  );

  task automatic chk(string req, bit ok, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refCrc(logic [31:0] c, logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[31] ^ d[i];
      c = c << 1;
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  task automatic runPkt(int len, logic [7:0] user);
    logic [7:0] dat[];
    logic [7:0] expB[$], gotD[$];
    bit gotS[$], gotL[$];
    int idx = 0, pad, tot, guard = 0;
    bit done = 0, pend = 0;
    logic [31:0] c;
    int firstBad;
    dat = new[len];
    foreach (dat[i]) dat[i] = 8'($urandom);
    while (!done && guard < 20000) begin
      guard++;
      @(negedge clk);
      if (!pend) inValid = (idx < len) && ($urandom % 4 != 0);
      inData = dat[idx < len ? idx : 0];
      inSop = (idx == 0); inEop = (idx == len - 1); pktUser = user;
      outReady = ($urandom % 4 != 0);
      #2;
      pend = inValid && !inReady;
      if (inValid && inReady) idx++;
      if (outValid && outReady) begin
        gotD.push_back(outData); gotS.push_back(cellStart); gotL.push_back(lastCell);
        if (lastCell) done = 1;
      end
    end
    inValid = 0;
    pad = (48 - (len + 8) % 48) % 48;
    tot = len + pad + 8;
    foreach (dat[i]) expB.push_back(dat[i]);
    repeat (pad) expB.push_back(8'h00);
    expB.push_back(user); expB.push_back(8'h00);
    expB.push_back(8'(len >> 8)); expB.push_back(8'(len));
    c = 32'hFFFF_FFFF;
    foreach (expB[i]) c = refCrc(c, expB[i]);
    c = ~c;
    for (int k = 3; k >= 0; k--) expB.push_back(c[8*k +: 8]);
    // R3 total size and R8 input count
    chk("R3 total bytes", gotD.size() == tot && tot % 48 == 0, gotD.size(), tot);
    chk("R8 input bytes accepted", idx == len, idx, len);
    if (gotD.size() != tot) return;
    firstBad = -1;
    for (int i = 0; i < len; i++) if (firstBad < 0 && gotD[i] != expB[i]) firstBad = i;
    chk("R2 data bytes", firstBad < 0, firstBad < 0 ? 0 : gotD[firstBad], firstBad < 0 ? 0 : expB[firstBad]);
    firstBad = -1;
    for (int i = len; i < len + pad; i++) if (firstBad < 0 && gotD[i] != 8'h00) firstBad = i;
    chk("R3 zero pad", firstBad < 0, firstBad < 0 ? 0 : gotD[firstBad], 0);
    chk("R4 trailer user/cpi", {gotD[tot-8], gotD[tot-7]} == {user, 8'h00},
        {gotD[tot-8], gotD[tot-7]}, {user, 8'h00});
    chk("R5 length field", {gotD[tot-6], gotD[tot-5]} == 16'(len), {gotD[tot-6], gotD[tot-5]}, len);
    chk("R6 crc bytes", {gotD[tot-4], gotD[tot-3], gotD[tot-2], gotD[tot-1]} == c,
        {gotD[tot-4], gotD[tot-3], gotD[tot-2], gotD[tot-1]}, c);
    firstBad = -1;
    for (int i = 0; i < tot; i++) if (firstBad < 0 && gotS[i] != (i % 48 == 0)) firstBad = i;
    chk("R1 R9 cell start pattern", firstBad < 0, firstBad, -1);
    firstBad = -1;
    for (int i = 0; i < tot; i++) if (firstBad < 0 && gotL[i] != (i == tot - 1)) firstBad = i;
    chk("R7 last cell flag", firstBad < 0, firstBad, -1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #2;
    // R9 reset state
    chk("R9 outValid in reset", outValid == 0, outValid, 0);
    rstN = 1'b1;
    @(negedge clk); #2;
    chk("R9 outValid idle after reset", outValid == 0, outValid, 0);
    runPkt(40, 8'hA5);  // R3 trailer right after data
    runPkt(41, 8'h3C);  // R3 extra cell
    runPkt(48, 8'h01);  // R3 data ends on boundary
    runPkt(1, 8'hFF);
    runPkt(88, 8'h77);
    runPkt(89, 8'h12);
    for (int p = 0; p < 25; p++) runPkt(1 + $urandom % 200, 8'($urandom));
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule